// File: doc/BRIEF.md
# Ternary-Spike Integrate-and-Fire Classifier Layer

This block is a single fully connected layer of spiking neurons used as a rate-coded classifier. A stream of input events, each naming one of 144 inputs (one per pixel of a 12×12 image), is offered over a valid/ready handshake. For every accepted event, all 10 neurons add the synaptic weight that links the named input to them into a signed membrane accumulator. The operation is an accumulate only, with no multiplication. A neuron fires a positive spike when its accumulator reaches the positive threshold and a negative spike when it reaches the negative threshold. The threshold magnitude is then removed toward zero, so the residue stays in the accumulator.

Each weight is held as two banks of four unit cells, one bank for the positive part and one for the negative part. The effective weight lies in -4..+4 and equals the number of set cells in the positive bank minus the number of set cells in the negative bank. After a spike, a neuron is refractory for a programmable number of input events. During that time it cannot fire, but it keeps integrating. Per-neuron scores count positive minus negative spikes, and the class output names the neuron with the highest score.

A host loads weights while no image is in progress. It opens an image with a start strobe, streams events, and closes the image with an end strobe.

Top module: `snn_ternary_layer`

## Requirements
- R1: After reset, ev_ready is 0, both spike vectors are 0, class_idx is 0 and every stored weight is 0.
- R2: A write stores wr_pos and wr_neg for the synapse (wr_in, wr_nrn). The synapse's weight is $countones(wr_pos) - $countones(wr_neg). A write is ignored while an image is active.
- R3: img_start clears all accumulators, refractory counters and scores, and raises ev_ready on the next cycle. img_end, when img_start is low, drops ev_ready on the next cycle. An event is accepted only when ev_valid and ev_ready are both high.
- R4: An accepted event with index i adds the weight (i, n) to the accumulator of every neuron n. The resulting spikes appear on spk_pos/spk_neg in the cycle after acceptance, as one-cycle pulses. Without an accepted event, no spike appears.
- R5: A non-refractory neuron whose new sum s reaches +TH (TH = 4) fires spk_pos and keeps s-TH. If s reaches -TH, it fires spk_neg and keeps s+TH. Otherwise it keeps s. A neuron never fires both polarities at once.
- R6: A single event through a weight of +4 or -4 makes a non-refractory neuron with a zero accumulator fire with the matching polarity.
- R7: After a spike, the next refr_len accepted events cannot make the neuron fire, but their weights are still added. A pending crossing fires on the first event after that, even through a zero weight.
- R8: The accumulator saturates at -128 and +127 (8-bit signed) instead of wrapping.
- R9: Each neuron's score is incremented on a positive spike and decremented on a negative spike. It saturates at -128 and +127.
- R10: class_idx is the index of the highest score. Ties go to the lowest index.
- R11: An event whose index is 144 or larger contributes weight 0 to every neuron, but it still counts as an event for refractory timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_start | input | 1 | Start-of-image strobe: clears state and opens the image |
| img_end | input | 1 | End-of-image strobe: closes the image |
| wr_en | input | 1 | Weight write strobe |
| wr_nrn | input | 4 | Neuron index of the write |
| wr_in | input | 8 | Input index of the write |
| wr_pos | input | 4 | Positive cell bank |
| wr_neg | input | 4 | Negative cell bank |
| refr_len | input | 4 | Refractory length in input events |
| ev_valid | input | 1 | Input event offered |
| ev_idx | input | 8 | Input index of the event |
| ev_ready | output | 1 | Event can be accepted (image active) |
| spk_pos | output | 10 | Positive spike pulses, one bit per neuron |
| spk_neg | output | 10 | Negative spike pulses, one bit per neuron |
| class_idx | output | 4 | Index of the neuron with the highest score |

## Verification
The assertions rely on a few rules for the inputs. refr_len is stable for the whole of an image. img_start never arrives in the same cycle as an offered event, and TH never exceeds the largest weight. The weight-driven firing check also assumes that the accumulator reflects only the events accepted since the last start strobe. The stimulus follows these rules: it changes refr_len only while no image is active, pulses the strobes on cycles with ev_valid low, and loads weights before opening an image. The one exception is a deliberate write inside an image, which the design must ignore.

// File: rtl/snn_layer_pkg.sv
package snn_layer_pkg;
  localparam int CELLS = 4;
  localparam int WGT_W = $clog2(CELLS + 1) + 1;

  typedef struct packed {
    logic [CELLS-1:0] up;
    logic [CELLS-1:0] dn;
  } syn_cells_t;

  typedef logic signed [WGT_W-1:0] syn_wgt_t;

  // effective weight: set cells in the upper bank minus set cells in the lower bank
  function automatic syn_wgt_t cells_to_weight(syn_cells_t c);
    syn_wgt_t up_n;
    syn_wgt_t dn_n;
    up_n = '0;
    dn_n = '0;
    for (int k = 0; k < CELLS; k++) begin
      up_n = up_n + syn_wgt_t'({1'b0, c.up[k]});
      dn_n = dn_n + syn_wgt_t'({1'b0, c.dn[k]});
    end
    return up_n - dn_n;
  endfunction
endpackage

// File: rtl/snn_weight_store.sv
module snn_weight_store
  import snn_layer_pkg::*;
#(
  parameter int N_IN  = 144,
  parameter int N_OUT = 10,
  parameter int IDX_W = 8,
  parameter int NRN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_in,
  input  logic [NRN_W-1:0]       wr_nrn,
  input  syn_cells_t             wr_cells,
  input  logic [IDX_W-1:0]       rd_idx,
  output syn_wgt_t [N_OUT-1:0]   rd_wgt,
  output logic                   wr_taken
);
  localparam logic [IDX_W-1:0] LAST_IN  = IDX_W'(N_IN - 1);
  localparam logic [NRN_W-1:0] LAST_NRN = NRN_W'(N_OUT - 1);

  syn_cells_t mem [N_IN][N_OUT];
  logic       rd_ok;

  assign wr_taken = wr_en && !lock && (wr_in <= LAST_IN) && (wr_nrn <= LAST_NRN);
  assign rd_ok    = (rd_idx <= LAST_IN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < N_IN; a++)
        for (int b = 0; b < N_OUT; b++)
          mem[a][b] <= '0;
    end else if (wr_taken) begin
      mem[wr_in][wr_nrn] <= wr_cells;
    end
  end

  always_comb begin
    for (int n = 0; n < N_OUT; n++)
      rd_wgt[n] = rd_ok ? cells_to_weight(mem[rd_idx][n]) : '0;
  end

  // R2: a write is accepted only while the store is unlocked
  a_r2_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en) |-> !wr_taken);
endmodule

// File: rtl/snn_if_neuron.sv
module snn_if_neuron
  import snn_layer_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int TH     = 4,
  parameter int REFR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ev_acc,
  input  syn_wgt_t          wgt,
  input  logic [REFR_W-1:0] refr_len,
  output logic              fire_up,
  output logic              fire_dn,
  output logic              spk_up,
  output logic              spk_dn
);
  localparam logic signed [ACC_W-1:0] TH_P  = ACC_W'(TH);
  localparam logic signed [ACC_W-1:0] TH_N  = -TH_P;
  localparam logic signed [ACC_W:0]   MAX_W = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   MIN_W = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc;
  logic [REFR_W-1:0]       refr;
  logic signed [ACC_W:0]   sum_w;
  logic signed [ACC_W-1:0] sum_s;
  logic                    in_refr;

  function automatic logic signed [ACC_W-1:0] clamp(logic signed [ACC_W:0] v);
    if (v > MAX_W) return MAX_W[ACC_W-1:0];
    if (v < MIN_W) return MIN_W[ACC_W-1:0];
    return v[ACC_W-1:0];
  endfunction

  assign sum_w   = {acc[ACC_W-1], acc} + {{(ACC_W + 1 - WGT_W){wgt[WGT_W-1]}}, wgt};
  assign sum_s   = clamp(sum_w);
  assign in_refr = (refr != '0);
  assign fire_up = ev_acc && !in_refr && (sum_s >= TH_P);
  assign fire_dn = ev_acc && !in_refr && (sum_s <= TH_N);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc    <= '0;
      refr   <= '0;
      spk_up <= 1'b0;
      spk_dn <= 1'b0;
    end else begin
      spk_up <= fire_up;
      spk_dn <= fire_dn;
      if (ev_acc) begin
        if (fire_up) begin
          acc  <= sum_s - TH_P;
          refr <= refr_len;
        end else if (fire_dn) begin
          acc  <= sum_s + TH_P;
          refr <= refr_len;
        end else begin
          acc  <= sum_s;
          if (in_refr) refr <= refr - REFR_W'(1);
        end
      end
    end
  end

  // R5: never both polarities
  a_r5_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !(spk_up && spk_dn));
  // R4: no spike without an accepted event
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_acc && !clear) |=> (!spk_up && !spk_dn));
  // R7: a refractory neuron stays silent on an event
  a_r7_quiet_in_refr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && in_refr) |=> (!spk_up && !spk_dn));
  // R6: a full weight from a non-negative accumulator fires
  a_r6_full_up_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && !clear && !in_refr && !acc[ACC_W-1] && wgt == WGT_W'(TH)) |=> spk_up);
  a_r6_full_dn_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc && !clear && !in_refr && (acc <= 0) && wgt == -WGT_W'(TH)) |=> spk_dn);
endmodule

// File: rtl/snn_score_argmax.sv
module snn_score_argmax #(
  parameter int N_OUT = 10,
  parameter int CNT_W = 8,
  parameter int NRN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [N_OUT-1:0] hit_up,
  input  logic [N_OUT-1:0] hit_dn,
  input  logic [N_OUT-1:0] spk_up,
  input  logic [N_OUT-1:0] spk_dn,
  output logic [NRN_W-1:0] class_idx
);
  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W-1:0] score [N_OUT];
  logic signed [CNT_W-1:0] best_v;

  for (genvar i = 0; i < N_OUT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        score[i] <= '0;
      end else if (hit_up[i] && !hit_dn[i] && score[i] != CNT_MAX) begin
        score[i] <= score[i] + CNT_W'(1);
      end else if (hit_dn[i] && !hit_up[i] && score[i] != CNT_MIN) begin
        score[i] <= score[i] - CNT_W'(1);
      end
    end

    // R9: a positive spike pulse matches a score step of +1 or a saturated score
    a_r9_up_counts: assert property (@(posedge clk) disable iff (!rst_n)
      spk_up[i] |-> ((score[i] - $past(score[i])) == CNT_W'(1) || score[i] == CNT_MAX));
    a_r9_dn_counts: assert property (@(posedge clk) disable iff (!rst_n)
      spk_dn[i] |-> (($past(score[i]) - score[i]) == CNT_W'(1) || score[i] == CNT_MIN));
    // R10: the chosen class is never beaten, and ties resolve low
    a_r10_best: assert property (@(posedge clk) disable iff (!rst_n)
      score[i] <= score[class_idx]);
    a_r10_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (score[i] == score[class_idx]) |-> (NRN_W'(i) >= class_idx));
  end

  always_comb begin
    class_idx = '0;
    best_v    = score[0];
    for (int i = 1; i < N_OUT; i++) begin
      if (score[i] > best_v) begin
        best_v    = score[i];
        class_idx = NRN_W'(i);
      end
    end
  end
endmodule

// File: rtl/snn_ternary_layer.sv
module snn_ternary_layer
  import snn_layer_pkg::*;
#(
  parameter int N_IN   = 144,
  parameter int N_OUT  = 10,
  parameter int ACC_W  = 8,
  parameter int TH     = 4,
  parameter int REFR_W = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(N_IN),
  localparam int NRN_W = $clog2(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              img_start,
  input  logic              img_end,
  input  logic              wr_en,
  input  logic [NRN_W-1:0]  wr_nrn,
  input  logic [IDX_W-1:0]  wr_in,
  input  logic [CELLS-1:0]  wr_pos,
  input  logic [CELLS-1:0]  wr_neg,
  input  logic [REFR_W-1:0] refr_len,
  input  logic              ev_valid,
  input  logic [IDX_W-1:0]  ev_idx,
  output logic              ev_ready,
  output logic [N_OUT-1:0]  spk_pos,
  output logic [N_OUT-1:0]  spk_neg,
  output logic [NRN_W-1:0]  class_idx
);
  logic                 active;
  logic                 ev_acc;
  logic                 wr_taken;
  syn_cells_t           wr_cells;
  syn_wgt_t [N_OUT-1:0] ev_wgt;
  logic [N_OUT-1:0]     fire_up;
  logic [N_OUT-1:0]     fire_dn;

  always_ff @(posedge clk) begin
    if (!rst_n)          active <= 1'b0;
    else if (img_start)  active <= 1'b1;
    else if (img_end)    active <= 1'b0;
  end

  assign ev_ready = active;
  assign ev_acc   = ev_valid && active && !img_start;
  assign wr_cells = '{up: wr_pos, dn: wr_neg};

  snn_weight_store #(
    .N_IN(N_IN), .N_OUT(N_OUT), .IDX_W(IDX_W), .NRN_W(NRN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .lock(active), .wr_en(wr_en),
    .wr_in(wr_in), .wr_nrn(wr_nrn), .wr_cells(wr_cells),
    .rd_idx(ev_idx), .rd_wgt(ev_wgt), .wr_taken(wr_taken)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_nrn
    snn_if_neuron #(
      .ACC_W(ACC_W), .TH(TH), .REFR_W(REFR_W)
    ) u_nrn (
      .clk(clk), .rst_n(rst_n), .clear(img_start), .ev_acc(ev_acc),
      .wgt(ev_wgt[n]), .refr_len(refr_len),
      .fire_up(fire_up[n]), .fire_dn(fire_dn[n]),
      .spk_up(spk_pos[n]), .spk_dn(spk_neg[n])
    );
  end

  snn_score_argmax #(
    .N_OUT(N_OUT), .CNT_W(CNT_W), .NRN_W(NRN_W)
  ) u_score (
    .clk(clk), .rst_n(rst_n), .clear(img_start),
    .hit_up(fire_up), .hit_dn(fire_dn),
    .spk_up(spk_pos), .spk_dn(spk_neg), .class_idx(class_idx)
  );

  // R3: strobes open and close the image one cycle later
  a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    img_start |=> ev_ready);
  a_r3_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (img_end && !img_start) |=> !ev_ready);
  // R2: no write lands while an image is active
  a_r2_no_write_active: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |-> !wr_taken);
endmodule

// File: tb/snn_ternary_layer_tb_top.sv
module snn_ternary_layer_tb_top;
  localparam int NI = 144;
  localparam int NO = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       img_start = 1'b0, img_end = 1'b0, wr_en = 1'b0, ev_valid = 1'b0;
  logic [3:0] wr_nrn = '0, wr_pos = '0, wr_neg = '0, refr_len = 4'd2;
  logic [7:0] wr_in = '0, ev_idx = '0;
  logic       ev_ready;
  logic [NO-1:0] spk_pos, spk_neg;
  logic [3:0] class_idx;

  snn_ternary_layer dut_i (
    .clk(clk), .rst_n(rst_n), .img_start(img_start), .img_end(img_end),
    .wr_en(wr_en), .wr_nrn(wr_nrn), .wr_in(wr_in), .wr_pos(wr_pos), .wr_neg(wr_neg),
    .refr_len(refr_len), .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_ready(ev_ready),
    .spk_pos(spk_pos), .spk_neg(spk_neg), .class_idx(class_idx)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // independent model state
  int wm [NO][NI];
  int m_acc [NO];
  int m_ref [NO];
  int m_sc [NO];
  bit m_active = 0;

  typedef struct {
    logic [NO-1:0] p;
    logic [NO-1:0] n;
    int            cls;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic bit [3:0] therm(int k);
    return 4'((1 << k) - 1);
  endfunction

  function automatic int best_class();
    int b = 0;
    for (int i = 1; i < NO; i++) if (m_sc[i] > m_sc[b]) b = i;
    return b;
  endfunction

  task automatic put_w(int n, int i, bit [3:0] p, bit [3:0] q);
    wr_en = 1; wr_nrn = 4'(n); wr_in = 8'(i); wr_pos = p; wr_neg = q;
    if (!m_active) wm[n][i] = $countones(p) - $countones(q);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic open_img();
    img_start = 1;
    m_active = 1;
    for (int n = 0; n < NO; n++) begin m_acc[n] = 0; m_ref[n] = 0; m_sc[n] = 0; end
    @(posedge clk); @(negedge clk);
    img_start = 0;
  endtask

  task automatic close_img();
    img_end = 1;
    m_active = 0;
    @(posedge clk); @(negedge clk);
    img_end = 0;
  endtask

  // driver: predicts the outcome of one event and queues it for the monitor
  task automatic send_ev(int idx, string tag);
    exp_t e;
    e.p = '0; e.n = '0; e.tag = tag;
    ev_valid = 1; ev_idx = 8'(idx);
    for (int n = 0; n < NO; n++) begin
      int s;
      s = lim(m_acc[n] + ((idx < NI) ? wm[n][idx] : 0), -128, 127);
      if (m_ref[n] == 0 && s >= 4) begin
        e.p[n] = 1; m_acc[n] = s - 4; m_ref[n] = int'(refr_len);
        m_sc[n] = lim(m_sc[n] + 1, -128, 127);
      end else if (m_ref[n] == 0 && s <= -4) begin
        e.n[n] = 1; m_acc[n] = s + 4; m_ref[n] = int'(refr_len);
        m_sc[n] = lim(m_sc[n] - 1, -128, 127);
      end else begin
        m_acc[n] = s;
        if (m_ref[n] > 0) m_ref[n]--;
      end
    end
    e.cls = best_class();
    @(posedge clk);
    sbq.push_back(e);
    @(negedge clk);
    ev_valid = 0;
  endtask

  // monitor: compares the cycle after acceptance
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(spk_pos == e.p, e.tag, "spk_pos", int'(spk_pos), int'(e.p));
      check(spk_neg == e.n, e.tag, "spk_neg", int'(spk_neg), int'(e.n));
      check(int'(class_idx) == e.cls, {e.tag, "/R10"}, "class_idx", int'(class_idx), e.cls);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int n = 0; n < NO; n++) for (int i = 0; i < NI; i++) wm[n][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(ev_ready == 0, "R1", "ev_ready", int'(ev_ready), 0);
    check(spk_pos == 0 && spk_neg == 0, "R1", "spikes", int'({spk_pos, spk_neg}), 0);
    check(class_idx == 0, "R1", "class_idx", int'(class_idx), 0);

    // R2: load weights with mixed cell patterns; input 0 gets +4 / -4
    for (int n = 0; n < NO; n++) begin
      for (int i = 0; i < NI; i++) begin
        int w;
        bit [3:0] p, q;
        w = ((n * 5 + i * 3 + 1) % 9) - 4;
        if (i == 0) w = (n % 2 == 0) ? 4 : -4;
        if (w >= 0 && w < 4 && i % 2 == 0) begin p = therm(w + 1); q = 4'b0001; end
        else if (w < 0 && w > -4 && i % 2 == 0) begin p = 4'b0001; q = therm(1 - w); end
        else if (w >= 0) begin p = therm(w); q = 4'b0000; end
        else begin p = 4'b0000; q = therm(-w); end
        put_w(n, i, p, q);
      end
    end

    // R3: open image
    refr_len = 4'd2;
    open_img();
    check(ev_ready == 1, "R3", "ev_ready after start", int'(ev_ready), 1);
    // R6: single full-weight event from a cleared neuron
    send_ev(0, "R6");
    // R7: refractory holds two events, the pending crossing fires on the third
    send_ev(0, "R7"); send_ev(0, "R7"); send_ev(0, "R7");
    send_ev(1, "R7"); send_ev(0, "R7");
    // R2: writes during an image are ignored
    put_w(0, 5, 4'b1111, 4'b0000);
    put_w(1, 5, 4'b0000, 4'b1111);
    for (int k = 0; k < 6; k++) send_ev(5, "R2");
    // R4, R5, R11: pseudo-random stream with some out-of-range indices
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      int idx;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      idx = int'(lf[7:0]);
      send_ev(idx, (idx >= NI) ? "R11" : "R4/R5");
    end
    repeat (2) @(negedge clk);
    close_img();
    check(ev_ready == 0, "R3", "ev_ready after end", int'(ev_ready), 0);

    // R2: idle write now takes effect
    put_w(0, 5, 4'b1111, 4'b0000);
    // R8: long refractory drives accumulators into saturation
    refr_len = 4'd15;
    open_img();
    check(class_idx == 0, "R3", "class after clear", int'(class_idx), 0);
    for (int k = 0; k < 80; k++) send_ev(0, "R8");
    for (int k = 0; k < 40; k++) send_ev(3, "R8");
    repeat (2) @(negedge clk);
    close_img();

    // R9: every event fires, scores saturate
    refr_len = 4'd0;
    open_img();
    for (int k = 0; k < 140; k++) send_ev(0, "R9");
    for (int k = 0; k < 20; k++) send_ev(5, "R9");
    repeat (2) @(negedge clk);
    close_img();

    // R3: start clears accumulators: a fresh image behaves like the first
    refr_len = 4'd2;
    open_img();
    send_ev(0, "R3");
    send_ev(7, "R3");
    repeat (3) @(negedge clk);
    check(spk_pos == 0 && spk_neg == 0, "R4", "no spike when idle",
          int'({spk_pos, spk_neg}), 0);
    close_img();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule